// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry Flag

This block moves an N-bit word left or right by a count supplied as an operand, in one of seven ways: zero-filling shifts in both directions, a sign-preserving right shift, plain rotates in both directions, and rotates that pass through a carry flag. The carry flag is involved in every mode. It always ends up holding the last bit that left the word. In the two through-carry rotates, the carry and the word together form a single ring of N+1 bits.

A caller presents the word, the count, the operation code and the incoming carry, and raises `start` for one cycle. On the next clock edge the shifted word and the new carry are captured in output registers, and `done` is high for that one cycle. The outputs then keep their values until the next strobe. Counts larger than the word width are defined for every mode, so the caller never has to clamp or reduce the count.

Top module: `shrot_unit`

## Requirements
- R1: While reset is asserted (active-low `rst_n`), and after it is released before any strobe, `dout` is all zeros, `cout` is 0 and `done` is 0.
- R2: A cycle with `start` high loads `dout`/`cout` at the next clock edge and raises `done` for exactly that one cycle. In cycles without `start`, `done` is 0 and `dout`/`cout` keep their values, whatever the other inputs do.
- R3: A count of zero returns `dout` equal to `din` and `cout` equal to `cin`, for every operation code.
- R4: Operation code 0 is a zero-filling left shift. For a count k with 1 <= k <= N, the result is `din` shifted up by k with zeros in the low k bits, and `cout` is `din[N-k]`.
- R5: Operation code 1 is a zero-filling right shift. For 1 <= k <= N, zeros fill the high k bits and `cout` is `din[k-1]`.
- R6: Operation code 2 is a sign-preserving right shift. The original `din[N-1]` fills the vacated high bits, and `cout` is `din[k-1]` for k <= N. For k > N the result is all copies of the sign and `cout` equals the sign.
- R7: Operation codes 3 (left) and 4 (right) rotate the word without the carry, with the count taken modulo N. For a nonzero count, `cout` is a copy of the last bit rotated out: `dout[0]` after a left rotate, `dout[N-1]` after a right rotate.
- R8: Operation codes 5 (left) and 6 (right) rotate the N+1-bit ring formed by {`cin`, `din`}, with the count taken modulo N+1. The old carry enters the vacated end of the word and the last bit leaving the word becomes `cout`.
- R9: For both zero-filling shifts, a count of N or more gives an all-zero word. `cout` is the bit that left last when the count equals N (`din[0]` for a left shift, `din[N-1]` for a right shift), and 0 when the count exceeds N.
- R10: Operation code 7 leaves the word and carry untouched: `dout` becomes `din` and `cout` becomes `cin`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle strobe that captures a new result |
| op | input | 3 | Operation code (0..7, see requirements) |
| cnt | input | CNT_W | Shift or rotate count |
| din | input | WIDTH | Word to be shifted |
| cin | input | 1 | Incoming carry flag |
| dout | output | WIDTH | Registered shifted word |
| cout | output | 1 | Registered updated carry flag |
| done | output | 1 | High for one cycle when a new result is present |

## Verification
The block has a single register stage, so a fault in the next-state logic appears at `dout`/`cout` on the first edge after a strobe. The bench samples exactly there. A hold fault would show up as an output that changes, or a `done` that stays high, in a cycle with no strobe, and the bench looks for this over several idle cycles while it changes the inputs. Wrong carry routing is the subtle case: it can leave the word correct and flip only `cout`. For that reason, every check compares both outputs against a bench model that steps the word one bit at a time, across counts below, equal to and above N and N+1.

// File: rtl/shrot_pkg.sv
`timescale 1ns/1ps
package shrot_pkg;

    // Operation codes decoded by the shift/rotate unit
    typedef enum logic [2:0] {
        OP_LSL = 3'd0,  // zero-fill left
        OP_LSR = 3'd1,  // zero-fill right
        OP_ASR = 3'd2,  // sign-fill right
        OP_ROL = 3'd3,  // rotate left, word only
        OP_ROR = 3'd4,  // rotate right, word only
        OP_RCL = 3'd5,  // rotate left through carry
        OP_RCR = 3'd6,  // rotate right through carry
        OP_NOP = 3'd7   // pass word and carry through
    } shop_e;

endpackage

// File: rtl/shrot_shifter.sv
`timescale 1ns/1ps
// Zero-fill and sign-fill shifts with the last-out bit captured as carry.
// The word is widened by one guard bit on the side the bits leave from, so
// the guard bit ends up holding the last bit shifted out.
module shrot_shifter #(
    parameter int WIDTH = 16,
    parameter int CNT_W = 5
) (
    input  logic [WIDTH-1:0] din,
    input  logic [CNT_W-1:0] amt,
    output logic [WIDTH-1:0] lsl_word,
    output logic             lsl_carry,
    output logic [WIDTH-1:0] lsr_word,
    output logic             lsr_carry,
    output logic [WIDTH-1:0] asr_word,
    output logic             asr_carry
);
    localparam int EXT_W = WIDTH + 1;

    logic        [EXT_W-1:0] lsl_ext;
    logic        [EXT_W-1:0] lsr_ext;
    logic signed [EXT_W-1:0] asr_src;
    logic signed [EXT_W-1:0] asr_ext;

    // guard bit above the word catches what leaves the top
    assign lsl_ext   = {1'b0, din} << amt;
    assign lsl_word  = lsl_ext[WIDTH-1:0];
    assign lsl_carry = lsl_ext[WIDTH];

    // guard bit below the word catches what leaves the bottom
    assign lsr_ext   = {din, 1'b0} >> amt;
    assign lsr_word  = lsr_ext[EXT_W-1:1];
    assign lsr_carry = lsr_ext[0];

    // sign-extending variant; large counts saturate to copies of the sign
    assign asr_src   = {din, 1'b0};
    assign asr_ext   = asr_src >>> amt;
    assign asr_word  = asr_ext[EXT_W-1:1];
    assign asr_carry = asr_ext[0];

endmodule

// File: rtl/shrot_rotator.sv
`timescale 1ns/1ps
// Rotates a ring of RING_W bits both ways by a count reduced modulo RING_W.
// The modulo reduction uses masking when RING_W is a power of two and a
// divider otherwise.
module shrot_rotator #(
    parameter int RING_W = 16,
    parameter int CNT_W  = 5
) (
    input  logic [RING_W-1:0] ring,
    input  logic [CNT_W-1:0]  amt,
    output logic [RING_W-1:0] left_ring,
    output logic [RING_W-1:0] right_ring
);
    localparam bit IS_POW2 = ((RING_W & (RING_W - 1)) == 0);

    int unsigned steps;

    generate
        if (IS_POW2) begin : g_mask
            assign steps = 32'(amt) & 32'(RING_W - 1);
        end else begin : g_mod
            assign steps = 32'(amt) % 32'(RING_W);
        end
    endgenerate

    // a shift by RING_W or more yields zero, so steps == 0 needs no special case
    assign left_ring  = (ring << steps) | (ring >> (32'(RING_W) - steps));
    assign right_ring = (ring >> steps) | (ring << (32'(RING_W) - steps));

endmodule

// File: rtl/shrot_unit.sv
`timescale 1ns/1ps
module shrot_unit #(
    parameter int WIDTH = 16,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2:0]       op,
    input  logic [CNT_W-1:0] cnt,
    input  logic [WIDTH-1:0] din,
    input  logic             cin,
    output logic [WIDTH-1:0] dout,
    output logic             cout,
    output logic             done
);
    import shrot_pkg::*;

    localparam int RING_W = WIDTH + 1;

    typedef struct packed {
        logic [WIDTH-1:0] word;
        logic             carry;
        logic             done;
    } state_t;

    state_t state_d, state_q;
    shop_e  op_sel;

    logic [WIDTH-1:0]  lsl_w, lsr_w, asr_w;
    logic              lsl_c, lsr_c, asr_c;
    logic [WIDTH-1:0]  rol_w, ror_w;
    logic [RING_W-1:0] rcl_r, rcr_r;

    assign op_sel = shop_e'(op);

    shrot_shifter #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_shift (
        .din       (din),
        .amt       (cnt),
        .lsl_word  (lsl_w),
        .lsl_carry (lsl_c),
        .lsr_word  (lsr_w),
        .lsr_carry (lsr_c),
        .asr_word  (asr_w),
        .asr_carry (asr_c)
    );

    // word-only ring
    shrot_rotator #(.RING_W(WIDTH), .CNT_W(CNT_W)) u_rot_word (
        .ring       (din),
        .amt        (cnt),
        .left_ring  (rol_w),
        .right_ring (ror_w)
    );

    // carry-plus-word ring, carry in the top position
    shrot_rotator #(.RING_W(RING_W), .CNT_W(CNT_W)) u_rot_ring (
        .ring       ({cin, din}),
        .amt        (cnt),
        .left_ring  (rcl_r),
        .right_ring (rcr_r)
    );

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        if (start) begin
            state_d.done = 1'b1;
            if (cnt == '0) begin
                state_d.word  = din;
                state_d.carry = cin;
            end else begin
                unique case (op_sel)
                    OP_LSL: begin
                        state_d.word  = lsl_w;
                        state_d.carry = lsl_c;
                    end
                    OP_LSR: begin
                        state_d.word  = lsr_w;
                        state_d.carry = lsr_c;
                    end
                    OP_ASR: begin
                        state_d.word  = asr_w;
                        state_d.carry = asr_c;
                    end
                    OP_ROL: begin
                        // last bit out of the top re-entered at bit 0
                        state_d.word  = rol_w;
                        state_d.carry = rol_w[0];
                    end
                    OP_ROR: begin
                        state_d.word  = ror_w;
                        state_d.carry = ror_w[WIDTH-1];
                    end
                    OP_RCL: begin
                        {state_d.carry, state_d.word} = rcl_r;
                    end
                    OP_RCR: begin
                        {state_d.carry, state_d.word} = rcr_r;
                    end
                    default: begin
                        state_d.word  = din;
                        state_d.carry = cin;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign dout = state_q.word;
    assign cout = state_q.carry;
    assign done = state_q.done;

endmodule

// File: rtl/shrot_unit_chk.sv
`timescale 1ns/1ps
module shrot_unit_chk #(
    parameter int WIDTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [2:0]       op,
    input logic [CNT_W-1:0] cnt,
    input logic [WIDTH-1:0] din,
    input logic             cin,
    input logic [WIDTH-1:0] dout,
    input logic             cout,
    input logic             done
);
    // R2: a strobe is answered by done on the next edge
    a_r2_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    // R2: no strobe, no done
    a_r2_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);

    // R2: outputs hold without a strobe
    a_r2_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(dout) && $stable(cout)));

    // R3: zero count passes word and carry
    a_r3_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (start && cnt == '0) |=> (dout == $past(din) && cout == $past(cin)));

    // R7: plain rotate carry copies the bit that re-entered the word
    a_r7_rol_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == 3'd3 && cnt != '0) |=> (cout == dout[0]));

    a_r7_ror_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == 3'd4 && cnt != '0) |=> (cout == dout[WIDTH-1]));

    // R9: left shift past the width clears word and carry
    a_r9_lsl_beyond: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == 3'd0 && 32'(cnt) > WIDTH) |=> (dout == '0 && !cout));

    // R10: pass-through code
    a_r10_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == 3'd7) |=> (dout == $past(din) && cout == $past(cin)));

endmodule

bind shrot_unit shrot_unit_chk #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .op    (op),
    .cnt   (cnt),
    .din   (din),
    .cin   (cin),
    .dout  (dout),
    .cout  (cout),
    .done  (done)
);

// File: tb/shrot_unit_test.sv
`timescale 1ns/1ps
module shrot_unit_test;
    localparam int N  = 16;
    localparam int CW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [2:0]    op = 3'd0;
    logic [CW-1:0] cnt = '0;
    logic [N-1:0]  din = '0;
    logic          cin = 1'b0;
    logic [N-1:0]  dout;
    logic          cout;
    logic          done;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    shrot_unit #(.WIDTH(N), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .cnt(cnt),
        .din(din), .cin(cin), .dout(dout), .cout(cout), .done(done)
    );

    // one-bit-per-step model of every operation
    function automatic logic [N:0] model(input logic [2:0] o, input int k,
                                         input logic [N-1:0] d0, input logic c0);
        logic [N-1:0] d;
        logic         c;
        logic         t;
        d = d0;
        c = c0;
        for (int i = 0; i < k; i++) begin
            case (o)
                3'd0: begin c = d[N-1]; d = {d[N-2:0], 1'b0}; end
                3'd1: begin c = d[0];   d = {1'b0, d[N-1:1]}; end
                3'd2: begin c = d[0];   d = {d[N-1], d[N-1:1]}; end
                3'd3: begin c = d[N-1]; d = {d[N-2:0], d[N-1]}; end
                3'd4: begin c = d[0];   d = {d[0], d[N-1:1]}; end
                3'd5: begin t = d[N-1]; d = {d[N-2:0], c}; c = t; end
                3'd6: begin t = d[0];   d = {c, d[N-1:1]}; c = t; end
                default: ;
            endcase
        end
        return {c, d};
    endfunction

    task automatic check_bit(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // strobe one operation and compare both outputs after the capture edge
    task automatic run_op(input string tag, input logic [2:0] o, input int k,
                          input logic [N-1:0] d, input logic c);
        logic [N:0] exp;
        exp = model(o, k, d, c);
        @(negedge clk);
        op = o; cnt = CW'(k); din = d; cin = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n_checks++;
        if (dout !== exp[N-1:0] || cout !== exp[N] || done !== 1'b1) begin
            n_fails++;
            $display("FAIL %s op=%0d cnt=%0d din=%h cin=%b: actual dout=%h cout=%b done=%b expected dout=%h cout=%b done=1",
                     tag, o, k, d, c, dout, cout, done, exp[N-1:0], exp[N]);
        end
    endtask

    task automatic t_reset();
        n_checks++;
        if (dout !== '0) begin
            n_fails++;
            $display("FAIL R1 reset dout: actual=%h expected=0000", dout);
        end
        check_bit("R1 reset cout", cout, 1'b0);
        check_bit("R1 reset done", done, 1'b0);
    endtask

    task automatic t_lsl();
        run_op("R4 lsl k1", 3'd0, 1, 16'hB3C5, 1'b0);
        run_op("R4 lsl k2", 3'd0, 2, 16'h4001, 1'b1);
        run_op("R4 lsl k5", 3'd0, 5, 16'hB3C5, 1'b0);
        run_op("R4 lsl k15", 3'd0, 15, 16'h0003, 1'b0);
    endtask

    task automatic t_lsr();
        run_op("R5 lsr k1", 3'd1, 1, 16'hB3C5, 1'b0);
        run_op("R5 lsr k4", 3'd1, 4, 16'h00F8, 1'b1);
        run_op("R5 lsr k9", 3'd1, 9, 16'hB3C5, 1'b0);
    endtask

    task automatic t_asr();
        run_op("R6 asr neg k3", 3'd2, 3, 16'h8C05, 1'b0);
        run_op("R6 asr pos k3", 3'd2, 3, 16'h7C05, 1'b1);
        run_op("R6 asr neg k16", 3'd2, 16, 16'h8002, 1'b0);
        run_op("R6 asr neg k20", 3'd2, 20, 16'h9000, 1'b0);
        run_op("R6 asr pos k20", 3'd2, 20, 16'h7FFF, 1'b1);
    endtask

    task automatic t_rotate();
        run_op("R7 rol k2", 3'd3, 2, 16'hC001, 1'b0);
        run_op("R7 ror k2", 3'd4, 2, 16'h0006, 1'b1);
        run_op("R7 rol k16", 3'd3, 16, 16'h1235, 1'b0);
        run_op("R7 ror k16", 3'd4, 16, 16'h9234, 1'b0);
        run_op("R7 rol k19", 3'd3, 19, 16'hA50F, 1'b1);
        run_op("R7 ror k19", 3'd4, 19, 16'hA50F, 1'b0);
    endtask

    task automatic t_ring();
        run_op("R8 rcl k1", 3'd5, 1, 16'h8000, 1'b1);
        run_op("R8 rcr k1", 3'd6, 1, 16'h0001, 1'b1);
        run_op("R8 rcl k16", 3'd5, 16, 16'h5A3C, 1'b1);
        run_op("R8 rcr k16", 3'd6, 16, 16'h5A3C, 1'b0);
        run_op("R8 rcl k17", 3'd5, 17, 16'hC3A1, 1'b1);
        run_op("R8 rcr k17", 3'd6, 17, 16'hC3A1, 1'b0);
        run_op("R8 rcl k20", 3'd5, 20, 16'hE00F, 1'b0);
        run_op("R8 rcr k31", 3'd6, 31, 16'hE00F, 1'b1);
    endtask

    task automatic t_zero();
        for (int o = 0; o < 8; o++) begin
            run_op("R3 zero count", 3'(o), 0, 16'hD2B7, o[0]);
        end
    endtask

    task automatic t_far();
        run_op("R9 lsl k16", 3'd0, 16, 16'h0001, 1'b0);
        run_op("R9 lsr k16", 3'd1, 16, 16'h8000, 1'b0);
        run_op("R9 lsl k17", 3'd0, 17, 16'hFFFF, 1'b1);
        run_op("R9 lsr k31", 3'd1, 31, 16'hFFFF, 1'b1);
    endtask

    task automatic t_pass();
        run_op("R10 pass c1", 3'd7, 5, 16'h3C96, 1'b1);
        run_op("R10 pass c0", 3'd7, 31, 16'hF00D, 1'b0);
    endtask

    task automatic t_hold();
        logic [N:0] exp;
        exp = model(3'd3, 4, 16'h1357, 1'b0);
        run_op("R2 load", 3'd3, 4, 16'h1357, 1'b0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            op = 3'(i); cnt = CW'(i + 1); din = ~din; cin = ~cin;
            check_bit("R2 done low idle", done, 1'b0);
            n_checks++;
            if (dout !== exp[N-1:0] || cout !== exp[N]) begin
                n_fails++;
                $display("FAIL R2 hold: actual dout=%h cout=%b expected dout=%h cout=%b",
                         dout, cout, exp[N-1:0], exp[N]);
            end
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lsl();
        t_lsr();
        t_asr();
        t_rotate();
        t_ring();
        t_zero();
        t_far();
        t_pass();
        t_hold();
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL R2 watchdog expired: actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule